// File: doc/BRIEF.md
# First-Fit Translation Run Allocator

This block reserves a contiguous run of free translation entries large enough to cover a requested byte range, writes each entry of the run with the base of a successive page, and reports the bus address at which the range becomes visible. It owns two entry pools. A shared pool holds small-page entries and, in its low part, per-port super-page entries. A wide pool holds 64 MB entries. For each entry the block keeps a valid flag and a stored base. The same engine frees a run on request by clearing its entries.

A caller presents a map request made of a mode, a port, a start address and a length. It waits for a one-cycle `done` pulse (with `bus_addr`) or a one-cycle `fail` pulse. Freeing a run uses the release request: a pool, a first index and a count. A registered read port returns the stored base and valid flag of any entry. The datapath uses that port to translate addresses, and it also makes the fill results observable. The choice of mode and the moment of release are left to the caller.

Top module: `xlate_run_alloc`

## Requirements
- R1: The number of entries a request needs is `((start + len - 1) >> S) - (start >> S) + 1`, where S is the page shift of the mode. A successful request fills exactly that many entries.
- R2: A request whose length is zero, or whose need exceeds the window size of its mode, reports `fail` on the first clock edge after the accepting edge. It writes nothing.
- R3: Modes are encoded on `req_mode` as follows. 0 is the small-page mode: shared pool, indices 64..127, 256 KB pages, bus base 0. 1 is the 64 MB mode: wide pool, indices 0..63, bus base 0x40_0000_0000. 2 is the super-page mode: shared pool, indices port×32 .. port×32+31, 16 GB pages, bus base 0x80_0000_0000. Code 3 is rejected like R2.
- R4: The run chosen is the one with the lowest start index, inside the window, whose entries are all free (first fit).
- R5: Entry k of a run is written with (start rounded down to its page + k × page size) with bit 63 set, and its valid flag is set. The read port returns the stored value (`rd_data`) and the valid flag (`rd_valid`) one cycle after `rd_pool` (0 = shared, 1 = wide) and `rd_idx` are presented.
- R6: On success, `bus_addr` = mode base + found index × page size + (start mod page size).
- R7: When no free run fits in the window, the request reports `fail` and writes nothing.
- R8: The search examines one index per cycle, starting at the window's first index. A valid entry restarts the candidate one past it. A success pulses `done` 1 + S + need edges after the accepting edge, where S = found + need − first. A search that finds nothing pulses `fail` 1 + S edges after the accepting edge, where S = v − first + 1 and v is the lowest valid index at or above first + window − need.
- R9: A release clears `rel_count` entries, one per cycle, starting at `rel_first` in pool `rel_pool`. Each cleared entry reads back invalid with value 0. `done` pulses `rel_count` edges after the accepting edge. A zero count pulses `done` on the accepting edge itself.
- R10: `busy` is high from the accepting edge until the edge that pulses `done` or `fail`. Requests presented while busy are ignored. When a map request and a release are presented together in idle, the map request is taken and the release is dropped.
- R11: `done` and `fail` are never high together, and each `fail` lasts one cycle.
- R12: After reset, `busy`, `done` and `fail` are low and every entry reads back invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Map request strobe |
| req_mode | input | 2 | Mode code (R3) |
| req_port | input | 1 | Port, selects the super-page half |
| req_start | input | 64 | Start address of the range |
| req_len | input | 32 | Length of the range in bytes |
| rel_valid | input | 1 | Release request strobe |
| rel_pool | input | 1 | Pool to release in: 0 shared, 1 wide |
| rel_first | input | 7 | First index of the run |
| rel_count | input | 8 | Number of entries to clear |
| rd_pool | input | 1 | Read pool select |
| rd_idx | input | 7 | Read index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| bus_addr | output | 64 | Bus address of the last successful mapping |
| rd_data | output | 64 | Stored entry value, one cycle after the read |
| rd_valid | output | 1 | Stored entry valid flag, one cycle after the read |

## Verification
Each result has a fixed due cycle. A rejected request fails one edge after acceptance. A search fails 1 + S edges after acceptance, and a success completes 1 + S + need edges after it. A release completes after as many edges as it clears, and a read returns one edge later. The reference model works out the outcome and that latency from its own copy of the valid flags. Then, on every falling edge after acceptance, it compares `busy`, `done` and `fail`, and checks `bus_addr` on the completion cycle. After each operation, the run and a fixed entry are read back through the read port and compared with the model.

// File: rtl/xra_pkg.sv
package xra_pkg;
  typedef enum logic [1:0] {
    MODE_SMALL = 2'd0,
    MODE_MID   = 2'd1,
    MODE_SUPER = 2'd2,
    MODE_BAD   = 2'd3
  } map_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CALC, ST_SCAN, ST_FILL, ST_CLR
  } eng_state_e;

  localparam int unsigned ENTRY_W   = 64;
  localparam int unsigned VALID_BIT = 63;
endpackage

// File: rtl/xra_window.sv
module xra_window
  import xra_pkg::*;
#(
  parameter int unsigned SHARED_DEPTH = 128,
  parameter int unsigned WIDE_DEPTH   = 64,
  parameter int unsigned SUPER_WIN    = 32,
  parameter int unsigned NPORT        = 2,
  parameter int unsigned PORT_W       = 1,
  parameter int unsigned PW           = 8,
  parameter int unsigned SMALL_SHIFT  = 18,
  parameter int unsigned MID_SHIFT    = 26,
  parameter int unsigned SUPER_SHIFT  = 34,
  parameter logic [63:0] SMALL_BASE   = 64'h0,
  parameter logic [63:0] MID_BASE     = 64'h40_0000_0000,
  parameter logic [63:0] SUPER_BASE   = 64'h80_0000_0000
) (
  input  logic [1:0]        mode,
  input  logic [PORT_W-1:0] port,
  output logic              pool_wide,
  output logic              mode_ok,
  output logic [PW-1:0]     first,
  output logic [PW-1:0]     win,
  output logic [5:0]        shift,
  output logic [63:0]       base
);
  map_mode_e m;
  assign m = map_mode_e'(mode);

  always_comb begin
    pool_wide = 1'b0;
    mode_ok   = 1'b1;
    first     = PW'(NPORT * SUPER_WIN);
    win       = PW'(SHARED_DEPTH - NPORT * SUPER_WIN);
    shift     = 6'(SMALL_SHIFT);
    base      = SMALL_BASE;
    case (m)
      MODE_SMALL: ;
      MODE_MID: begin
        pool_wide = 1'b1;
        first     = '0;
        win       = PW'(WIDE_DEPTH);
        shift     = 6'(MID_SHIFT);
        base      = MID_BASE;
      end
      MODE_SUPER: begin
        first = PW'(port) * PW'(SUPER_WIN);
        win   = PW'(SUPER_WIN);
        shift = 6'(SUPER_SHIFT);
        base  = SUPER_BASE;
      end
      default: mode_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/xra_span.sv
module xra_span #(
  parameter int unsigned LEN_W = 32
) (
  input  logic [63:0]      start,
  input  logic [LEN_W-1:0] len,
  input  logic [5:0]       shift,
  output logic [63:0]      need,
  output logic [63:0]      offset,
  output logic [63:0]      aligned
);
  logic [63:0] mask;
  logic [63:0] last_byte;

  always_comb begin
    mask      = (64'd1 << shift) - 64'd1;
    offset    = start & mask;
    aligned   = start & ~mask;
    last_byte = start + 64'(len) - 64'd1;
    need      = (last_byte >> shift) - (start >> shift) + 64'd1;
  end
endmodule

// File: rtl/xra_pool.sv
module xra_pool #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_set,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_valid,
  output logic [DEPTH-1:0]         valid_vec
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;

  // Data array: no reset, single write and single registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= wr_set;
      rd_valid <= vld[rd_idx];
    end
  end

  assign valid_vec = vld;
endmodule

// File: rtl/xlate_run_alloc.sv
module xlate_run_alloc
  import xra_pkg::*;
#(
  parameter int unsigned SHARED_DEPTH = 128,
  parameter int unsigned WIDE_DEPTH   = 64,
  parameter int unsigned SUPER_WIN    = 32,
  parameter int unsigned NPORT        = 2,
  parameter int unsigned LEN_W        = 32,
  parameter int unsigned SMALL_SHIFT  = 18,
  parameter int unsigned MID_SHIFT    = 26,
  parameter int unsigned SUPER_SHIFT  = 34,
  parameter logic [63:0] SMALL_BASE   = 64'h0,
  parameter logic [63:0] MID_BASE     = 64'h40_0000_0000,
  parameter logic [63:0] SUPER_BASE   = 64'h80_0000_0000,
  localparam int unsigned SH_IW  = $clog2(SHARED_DEPTH),
  localparam int unsigned WD_IW  = $clog2(WIDE_DEPTH),
  localparam int unsigned IW     = (SH_IW > WD_IW) ? SH_IW : WD_IW,
  localparam int unsigned PW     = IW + 1,
  localparam int unsigned PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [PORT_W-1:0] req_port,
  input  logic [63:0]       req_start,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              rel_valid,
  input  logic              rel_pool,
  input  logic [IW-1:0]     rel_first,
  input  logic [PW-1:0]     rel_count,
  input  logic              rd_pool,
  input  logic [IW-1:0]     rd_idx,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [63:0]       bus_addr,
  output logic [63:0]       rd_data,
  output logic              rd_valid
);
  eng_state_e        state;
  logic [1:0]        mode_q;
  logic [PORT_W-1:0] port_q;
  logic [63:0]       start_q;
  logic [LEN_W-1:0]  len_q;
  logic              rel_wide_q;
  logic [PW-1:0]     need_q, last_q, idx_q, cand_q, run_q, fill_k, rem_q;
  logic [63:0]       fill_addr;
  logic              rd_sel_q;

  logic              w_wide, w_ok;
  logic [PW-1:0]     w_first, w_win;
  logic [5:0]        w_shift;
  logic [63:0]       w_base, need, offset, aligned;

  xra_window #(
    .SHARED_DEPTH(SHARED_DEPTH), .WIDE_DEPTH(WIDE_DEPTH), .SUPER_WIN(SUPER_WIN),
    .NPORT(NPORT), .PORT_W(PORT_W), .PW(PW), .SMALL_SHIFT(SMALL_SHIFT),
    .MID_SHIFT(MID_SHIFT), .SUPER_SHIFT(SUPER_SHIFT), .SMALL_BASE(SMALL_BASE),
    .MID_BASE(MID_BASE), .SUPER_BASE(SUPER_BASE)
  ) u_window (
    .mode(mode_q), .port(port_q), .pool_wide(w_wide), .mode_ok(w_ok),
    .first(w_first), .win(w_win), .shift(w_shift), .base(w_base)
  );

  xra_span #(.LEN_W(LEN_W)) u_span (
    .start(start_q), .len(len_q), .shift(w_shift),
    .need(need), .offset(offset), .aligned(aligned)
  );

  // Pool write port: fill during ST_FILL, clear during ST_CLR.
  logic              act_wide, wr_go, wr_set;
  logic [IW-1:0]     wr_idx;
  logic [63:0]       wr_data;
  logic [SHARED_DEPTH-1:0] sh_vec;
  logic [WIDE_DEPTH-1:0]   wd_vec;
  logic [63:0]       sh_rd, wd_rd;
  logic              sh_rv, wd_rv, cur_valid;

  always_comb begin
    act_wide = (state == ST_CLR) ? rel_wide_q : w_wide;
    wr_go    = (state == ST_FILL) || (state == ST_CLR);
    wr_set   = (state == ST_FILL);
    wr_idx   = IW'(cand_q + fill_k);
    wr_data  = fill_addr | (64'd1 << VALID_BIT);
    if (state == ST_CLR) begin
      wr_idx  = IW'(idx_q);
      wr_data = '0;
    end
    cur_valid = w_wide ? wd_vec[idx_q[WD_IW-1:0]] : sh_vec[idx_q[SH_IW-1:0]];
  end

  xra_pool #(.DEPTH(SHARED_DEPTH), .DW(ENTRY_W)) u_shared (
    .clk(clk), .rst(rst), .wr_en(wr_go && !act_wide), .wr_set(wr_set),
    .wr_idx(wr_idx[SH_IW-1:0]), .wr_data(wr_data), .rd_idx(rd_idx[SH_IW-1:0]),
    .rd_data(sh_rd), .rd_valid(sh_rv), .valid_vec(sh_vec)
  );

  xra_pool #(.DEPTH(WIDE_DEPTH), .DW(ENTRY_W)) u_wide (
    .clk(clk), .rst(rst), .wr_en(wr_go && act_wide), .wr_set(wr_set),
    .wr_idx(wr_idx[WD_IW-1:0]), .wr_data(wr_data), .rd_idx(rd_idx[WD_IW-1:0]),
    .rd_data(wd_rd), .rd_valid(wd_rv), .valid_vec(wd_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= 1'b0;
    else     rd_sel_q <= rd_pool;
  end
  assign rd_data  = rd_sel_q ? wd_rd : sh_rd;
  assign rd_valid = rd_sel_q ? wd_rv : sh_rv;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done <= 1'b0; fail <= 1'b0; bus_addr <= '0;
      mode_q <= '0; port_q <= '0; start_q <= '0; len_q <= '0; rel_wide_q <= 1'b0;
      need_q <= '0; last_q <= '0; idx_q <= '0; cand_q <= '0; run_q <= '0;
      fill_k <= '0; rem_q <= '0; fill_addr <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q <= req_mode; port_q <= req_port;
            start_q <= req_start; len_q <= req_len;
            state <= ST_CALC;
          end else if (rel_valid) begin
            if (rel_count == '0) done <= 1'b1;
            else begin
              rel_wide_q <= rel_pool;
              idx_q      <= PW'(rel_first);
              rem_q      <= rel_count;
              state      <= ST_CLR;
            end
          end
        end
        ST_CALC: begin
          if (!w_ok || len_q == '0 || need > 64'(w_win)) begin
            fail  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            need_q    <= PW'(need);
            last_q    <= w_first + w_win - PW'(need);
            idx_q     <= w_first;
            cand_q    <= w_first;
            run_q     <= '0;
            fill_addr <= aligned;
            state     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          idx_q <= idx_q + PW'(1);
          if (cur_valid) begin
            cand_q <= idx_q + PW'(1);
            run_q  <= '0;
            if (idx_q >= last_q) begin
              fail  <= 1'b1;
              state <= ST_IDLE;
            end
          end else if (run_q + PW'(1) == need_q) begin
            fill_k <= '0;
            state  <= ST_FILL;
          end else begin
            run_q <= run_q + PW'(1);
          end
        end
        ST_FILL: begin
          fill_k    <= fill_k + PW'(1);
          fill_addr <= fill_addr + (64'd1 << w_shift);
          if (fill_k + PW'(1) == need_q) begin
            done     <= 1'b1;
            bus_addr <= w_base + (64'(cand_q) << w_shift) + offset;
            state    <= ST_IDLE;
          end
        end
        ST_CLR: begin
          idx_q <= idx_q + PW'(1);
          rem_q <= rem_q - PW'(1);
          if (rem_q == PW'(1)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xra_chk.sv
module xra_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic rel_valid,
  input logic rel_count_zero,
  input logic busy,
  input logic done,
  input logic fail
);
  p_excl_r11: assert property (@(posedge clk) disable iff (rst) !(done && fail));

  p_fail_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> (busy && !done && !fail));

  p_end_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> !busy);

  p_rel_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid && rel_valid && rel_count_zero) |=> (done && !busy));

  p_rel_start_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid && rel_valid && !rel_count_zero) |=> busy);
endmodule

bind xlate_run_alloc xra_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rel_valid(rel_valid),
  .rel_count_zero(rel_count == '0), .busy(busy), .done(done), .fail(fail)
);

// File: tb/xlate_run_alloc_tb.sv
`timescale 1ns/100ps
module xlate_run_alloc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, rel_valid = 0, rel_pool = 0, rd_pool = 0;
  logic [1:0] req_mode = 0;
  logic [0:0] req_port = 0;
  logic [63:0] req_start = 0;
  logic [31:0] req_len = 0;
  logic [6:0] rel_first = 0, rd_idx = 0;
  logic [7:0] rel_count = 0;
  logic busy, done, fail, rd_valid;
  logic [63:0] bus_addr, rd_data;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  bit mv [2][128];
  longint unsigned md [2][128];
  bit mk [2][128];

  always #2.5 clk = ~clk;

  xlate_run_alloc u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_port(req_port), .req_start(req_start), .req_len(req_len),
    .rel_valid(rel_valid), .rel_pool(rel_pool), .rel_first(rel_first),
    .rel_count(rel_count), .rd_pool(rd_pool), .rd_idx(rd_idx),
    .busy(busy), .done(done), .fail(fail), .bus_addr(bus_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input bit cond, input string msg);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic win_of(input int mode, input int port, output int first,
                        output int win, output int sh, output int pool,
                        output longint unsigned base);
    first = 64; win = 64; sh = 18; pool = 0; base = 0;
    case (mode)
      1: begin first = 0; win = 64; sh = 26; pool = 1; base = 64'h40_0000_0000; end
      2: begin first = port * 32; win = 32; sh = 34; base = 64'h80_0000_0000; end
      3: win = 0;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input int pool, input int idx, input string tag);
    @(negedge clk);
    rd_pool = pool[0];
    rd_idx  = 7'(idx);
    @(negedge clk);
    check(rd_valid == mv[pool][idx], $sformatf("R5 %s valid[%0d][%0d] act=%0b exp=%0b",
          tag, pool, idx, rd_valid, mv[pool][idx]));
    if (mk[pool][idx])
      check(rd_data == md[pool][idx], $sformatf("R5 %s data[%0d][%0d] act=%h exp=%h",
            tag, pool, idx, rd_data, md[pool][idx]));
  endtask

  // extra: 1 = extra request/release while busy, 2 = release together with request
  task automatic do_req(input int mode, input int port, input longint unsigned start,
                        input longint unsigned len, input int extra, input string tag);
    int first, win, sh, pool, found, lst, sv, lat;
    longint unsigned base, page, off, need, exp_bus;
    bit ok;
    win_of(mode, port, first, win, sh, pool, base);
    page = 64'd1 << sh;
    off = start & (page - 1);
    ok = 0; found = -1; lat = 1; need = 0; exp_bus = 0;
    if (mode != 3 && len != 0) begin
      need = ((start + len - 1) >> sh) - (start >> sh) + 1;
      if (need <= longint'(win)) begin
        lst = first + win - int'(need);
        for (int c = first; c <= lst && found < 0; c++) begin
          bit fr;
          fr = 1;
          for (int j = 0; j < int'(need); j++) if (mv[pool][c + j]) fr = 0;
          if (fr) found = c;
        end
        if (found >= 0) begin
          ok = 1;
          sv = found + int'(need) - first;
          lat = 1 + sv + int'(need);
          exp_bus = base + (longint'(found) << sh) + off;
        end else begin
          int v;
          v = lst;
          while (!mv[pool][v]) v++;
          sv = v - first + 1;
          lat = 1 + sv;
        end
      end
    end
    @(negedge clk);
    req_valid = 1; req_mode = 2'(mode); req_port = 1'(port);
    req_start = start; req_len = 32'(len);
    if (extra == 2) begin rel_valid = 1; rel_pool = 0; rel_first = 64; rel_count = 1; end
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
    check(busy == 1, $sformatf("R10 %s busy after accept act=%0b exp=1", tag, busy));
    if (extra == 1) begin
      req_valid = 1; req_mode = 0; req_start = 64'h7_0000_0000; req_len = 32'h40000;
      rel_valid = 1; rel_pool = 0; rel_first = 64; rel_count = 1;
    end
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      req_valid = 0; rel_valid = 0;
      if (k < lat)
        check(busy && !done && !fail, $sformatf("R8 %s cycle %0d act=b%0b d%0b f%0b exp=b1 d0 f0",
              tag, k, busy, done, fail));
      else begin
        check(done == ok && fail == !ok && !busy,
              $sformatf("R8 %s end cycle %0d act=b%0b d%0b f%0b exp=b0 d%0b f%0b",
              tag, k, busy, done, fail, ok, !ok));
        if (ok) check(bus_addr == exp_bus, $sformatf("R6 %s bus act=%h exp=%h", tag, bus_addr, exp_bus));
      end
    end
    @(negedge clk);
    check(!done && !fail && !busy, $sformatf("R11 %s after pulse act=b%0b d%0b f%0b exp=0 0 0",
          tag, busy, done, fail));
    if (ok) begin
      for (int j = 0; j < int'(need); j++) begin
        mv[pool][found + j] = 1;
        md[pool][found + j] = ((start - off) + longint'(j) * page) | (64'd1 << 63);
        mk[pool][found + j] = 1;
      end
      for (int j = 0; j < int'(need); j++) rd_chk(pool, found + j, {tag, " R1 run"});
    end
    rd_chk(0, 64, {tag, " R10 entry64"});
  endtask

  task automatic do_rel(input int pool, input int first, input int count, input string tag);
    @(negedge clk);
    rel_valid = 1; rel_pool = pool[0]; rel_first = 7'(first); rel_count = 8'(count);
    @(negedge clk);
    rel_valid = 0;
    if (count == 0)
      check(done && !busy, $sformatf("R9 %s zero count act=d%0b b%0b exp=d1 b0", tag, done, busy));
    else begin
      check(busy, $sformatf("R9 %s busy act=%0b exp=1", tag, busy));
      for (int k = 1; k <= count; k++) begin
        @(negedge clk);
        if (k < count) check(busy && !done, $sformatf("R9 %s cycle %0d act=b%0b d%0b exp=b1 d0",
                             tag, k, busy, done));
        else check(done && !busy, $sformatf("R9 %s end act=b%0b d%0b exp=b0 d1", tag, busy, done));
      end
    end
    @(negedge clk);
    check(!done, $sformatf("R9 %s after pulse act=%0b exp=0", tag, done));
    for (int j = 0; j < count; j++) begin
      mv[pool][first + j] = 0; md[pool][first + j] = 0; mk[pool][first + j] = 1;
    end
    for (int j = 0; j < count; j++) rd_chk(pool, first + j, {tag, " R9 cleared"});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !done && !fail, $sformatf("R12 reset outputs act=b%0b d%0b f%0b exp=0 0 0",
          busy, done, fail));
    rd_chk(0, 64, "R12 reset");
    rd_chk(1, 0, "R12 reset");
    rd_chk(0, 5, "R12 reset");
    do_req(0, 0, 64'h12_3456_7890, 64'h4_0000, 0, "R1 small two pages");
    do_req(0, 0, 64'h1_0000_0000, 64'hA_0000, 1, "R10 small while busy");
    do_rel(0, 64, 2, "R9 free head");
    do_req(0, 0, 64'h2_0000_0100, 64'hB_FF00, 0, "R4 skip small hole");
    do_req(0, 0, 64'h3_0000_0000, 64'h8_0000, 2, "R4 fill hole R10 req wins");
    do_req(1, 0, 64'h123_0456_7000, 64'h1000_0000, 0, "R3 mid");
    do_req(2, 0, 64'h456_0000_0123, 64'h8000_0000, 0, "R3 super port0");
    do_req(2, 1, 64'h456_0000_0123, 64'h8000_0000, 0, "R3 super port1");
    do_req(2, 1, 64'h457_FFFF_0000, 64'h2_0000, 0, "R1 super straddle");
    do_req(0, 0, 64'h0, 64'h200_0000, 0, "R2 too many pages");
    do_req(0, 0, 64'h5000, 64'h0, 0, "R2 zero length");
    do_req(3, 0, 64'h5000, 64'h1000, 0, "R3 bad mode");
    do_req(0, 0, 64'h4_0000_0000, 64'hC0_0000, 0, "R4 large small run");
    do_req(0, 0, 64'h5_0000_0000, 64'h80_0000, 0, "R7 no room");
    do_rel(0, 64, 0, "R9 zero");
    do_rel(1, 0, 5, "R9 wide");
    do_req(1, 0, 64'h9_0400_0000, 64'h400_0000, 0, "R6 mid after release");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule